// File: doc/BRIEF.md
# Privilege-Aware Virtual Address Segment Decoder

This block sorts each 64-bit virtual address into one of three outcomes before any translation lookup runs. An address can go to the translation buffer, it can map straight to a physical address, or it can raise an address error. The decision depends on the address bits and on the effective privilege level. That level comes from a 2-bit privilege field in the status word, and two exception-level flags override it. Each privilege level has its own 64-bit-mode enable, and the block reports the one that applies.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream. With the default `REG_OUT = 1`, a single register stage sits between the two streams. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high when the output stage is empty or is being drained in the same cycle. A response stays on the outputs, unchanged, until the downstream consumer accepts it with `rsp_ready`. With `REG_OUT = 0` the block is purely combinational: `rsp_valid` follows `req_valid` and `req_ready` follows `rsp_ready`.

Top module: `addrseg_decoder`

## Requirements
- R1: The privilege level decodes from `mode_priv` as follows: 00 is kernel, 01 is supervisor, 10 or 11 is user. When `mode_exc_lvl` or `mode_err_lvl` is set, the level is kernel regardless of `mode_priv`.
- R2: `rsp_wide` carries `wide_user` at user level, `wide_super` at supervisor level and `wide_kern` at kernel level.
- R3: When address bits 63:62 are binary 10, the outcome is direct at every privilege level. `rsp_paddr` is then address bits 43:0 and `rsp_writable` is 1.
- R4: Any address at or below 0x7FFFFFFF gives the use-TLB outcome at every privilege level.
- R5: If address bits 63:32 are zero and bit 31 is set, the address is treated as having bits 63:32 all ones before the upper-segment checks.
- R6: At kernel level, an address from 0xFFFFFFFF80000000 to 0xFFFFFFFFBFFFFFFF inclusive gives the direct outcome. `rsp_paddr` is then the low 29 address bits, zero-extended, and `rsp_writable` is 1.
- R7: At kernel level, any other address above 0x7FFFFFFF that R3 does not cover gives the use-TLB outcome.
- R8: At user or supervisor level, an address above 0x7FFFFFFF that R3 does not cover raises an address error. `rsp_exc_code` is then 5 for a write and 4 for a read, and `rsp_paddr` and `rsp_writable` are zero. For every outcome other than an address error, `rsp_exc_code` is 0.
- R9: While `rsp_valid` is high, exactly one of `rsp_use_tlb`, `rsp_direct` and `rsp_addr_err` is 1.
- R10: After reset `rsp_valid` is 0 and every response field is 0. With `REG_OUT = 1`, an accepted request appears at the outputs one cycle later. While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is 0 and the response holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_vaddr | input | 64 | Virtual address |
| req_write | input | 1 | 1 for a store, 0 for a load |
| mode_priv | input | 2 | Privilege field (00 kernel, 01 supervisor, 1x user) |
| mode_exc_lvl | input | 1 | Exception level flag; forces kernel |
| mode_err_lvl | input | 1 | Error level flag; forces kernel |
| wide_user | input | 1 | 64-bit mode enable for user level |
| wide_super | input | 1 | 64-bit mode enable for supervisor level |
| wide_kern | input | 1 | 64-bit mode enable for kernel level |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_use_tlb | output | 1 | Address must be looked up in the translation buffer |
| rsp_direct | output | 1 | Address maps directly to rsp_paddr |
| rsp_paddr | output | 44 | Direct physical address |
| rsp_writable | output | 1 | Direct mapping permits writes |
| rsp_addr_err | output | 1 | Address error raised |
| rsp_exc_code | output | 5 | 4 for a load address error, 5 for a store address error, else 0 |
| rsp_wide | output | 1 | Effective 64-bit mode flag |

## Verification
A wrong privilege decode shows at the ports as a kernel-only direct window that is granted to user code, or as an address error returned where the use-TLB or direct outcome was due. The vector table puts both overridden and non-overridden modes against the same upper address to expose this. A broken sign-extension or range compare first shows at the exact window edges (0x...BFFFFFFF against 0x...C0000000), or on 32-bit addresses with bit 31 set, as the wrong outcome or a truncated physical address. With the register stage, any such fault appears on the outputs in the cycle after the request is accepted. A flaw in the stall logic shows as a response that changes or is lost while `rsp_ready` is low.

// File: rtl/addrseg_pkg.sv
package addrseg_pkg;
  localparam int VA_W     = 64;
  localparam int PA_W     = 44;
  localparam int DIRECT_W = 29;
  localparam int CODE_W   = 5;

  localparam logic [CODE_W-1:0] EXC_ADDR_LOAD  = 5'd4;
  localparam logic [CODE_W-1:0] EXC_ADDR_STORE = 5'd5;

  typedef enum logic [1:0] {
    LVL_KERNEL = 2'b00,
    LVL_SUPER  = 2'b01,
    LVL_USER   = 2'b10
  } lvl_t;

  typedef struct packed {
    logic              use_tlb;
    logic              direct;
    logic              addr_err;
    logic [PA_W-1:0]   paddr;
    logic              writable;
    logic [CODE_W-1:0] code;
    logic              wide;
  } seg_rsp_t;
endpackage

// File: rtl/addrseg_priv.sv
module addrseg_priv
  import addrseg_pkg::*;
(
  input  logic [1:0] mode_priv,
  input  logic       mode_exc_lvl,
  input  logic       mode_err_lvl,
  input  logic       wide_user,
  input  logic       wide_super,
  input  logic       wide_kern,
  output logic       is_kernel,
  output logic       wide
);
  lvl_t lvl;

  always_comb begin
    if (mode_exc_lvl || mode_err_lvl) begin
      lvl = LVL_KERNEL;
    end else begin
      unique case (mode_priv)
        2'b00:   lvl = LVL_KERNEL;
        2'b01:   lvl = LVL_SUPER;
        default: lvl = LVL_USER;
      endcase
    end
  end

  always_comb begin
    unique case (lvl)
      LVL_KERNEL: wide = wide_kern;
      LVL_SUPER:  wide = wide_super;
      default:    wide = wide_user;
    endcase
  end

  assign is_kernel = (lvl == LVL_KERNEL);
endmodule

// File: rtl/addrseg_classify.sv
module addrseg_classify
  import addrseg_pkg::*;
#(
  parameter int VAW = VA_W,
  parameter int PAW = PA_W,
  parameter int DW  = DIRECT_W
) (
  input  logic [VAW-1:0] vaddr,
  input  logic           write,
  input  logic           is_kernel,
  output logic           use_tlb,
  output logic           direct,
  output logic           addr_err,
  output logic [PAW-1:0] paddr,
  output logic           writable,
  output logic [CODE_W-1:0] code
);
  localparam int HALF = VAW / 2;

  logic [VAW-1:0] ext;
  logic           low_seg;
  logic           xphys;
  logic           kwin;

  always_comb begin
    ext = vaddr;
    if (vaddr[VAW-1:HALF] == '0 && vaddr[HALF-1])
      ext[VAW-1:HALF] = '1;
  end

  assign xphys   = (vaddr[VAW-1:VAW-2] == 2'b10);
  assign low_seg = (vaddr[VAW-1:HALF-1] == '0);
  assign kwin    = (ext[VAW-1:HALF] == '1) && (ext[HALF-1:HALF-2] == 2'b10);

  always_comb begin
    use_tlb  = 1'b0;
    direct   = 1'b0;
    addr_err = 1'b0;
    paddr    = '0;
    writable = 1'b0;
    code     = '0;
    if (xphys) begin
      direct   = 1'b1;
      paddr    = vaddr[PAW-1:0];
      writable = 1'b1;
    end else if (low_seg) begin
      use_tlb = 1'b1;
    end else if (is_kernel) begin
      if (kwin) begin
        direct   = 1'b1;
        paddr    = {{(PAW-DW){1'b0}}, ext[DW-1:0]};
        writable = 1'b1;
      end else begin
        use_tlb = 1'b1;
      end
    end else begin
      addr_err = 1'b1;
      code     = write ? EXC_ADDR_STORE : EXC_ADDR_LOAD;
    end
  end
endmodule

// File: rtl/addrseg_outstage.sv
module addrseg_outstage
  import addrseg_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  input  seg_rsp_t in_data,
  output logic     out_valid,
  input  logic     out_ready,
  output seg_rsp_t out_data
);
  generate
    if (REG_OUT) begin : g_reg
      logic     q_valid;
      seg_rsp_t q_data;

      assign in_ready = !q_valid || out_ready;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q_valid <= 1'b0;
          q_data  <= '0;
        end else if (in_ready) begin
          q_valid <= in_valid;
          if (in_valid) q_data <= in_data;
        end
      end

      assign out_valid = q_valid;
      assign out_data  = q_data;

      // R10
      hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && !out_ready) |=> (q_valid && $stable(q_data)));
    end else begin : g_pass
      assign out_valid = in_valid;
      assign in_ready  = out_ready;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/addrseg_decoder.sv
module addrseg_decoder
  import addrseg_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  input  logic [1:0]        mode_priv,
  input  logic              mode_exc_lvl,
  input  logic              mode_err_lvl,
  input  logic              wide_user,
  input  logic              wide_super,
  input  logic              wide_kern,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_use_tlb,
  output logic              rsp_direct,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_writable,
  output logic              rsp_addr_err,
  output logic [CODE_W-1:0] rsp_exc_code,
  output logic              rsp_wide
);
  logic     kern;
  logic     wide;
  seg_rsp_t comb_rsp;
  seg_rsp_t out_rsp;

  addrseg_priv u_priv (
    .mode_priv    (mode_priv),
    .mode_exc_lvl (mode_exc_lvl),
    .mode_err_lvl (mode_err_lvl),
    .wide_user    (wide_user),
    .wide_super   (wide_super),
    .wide_kern    (wide_kern),
    .is_kernel    (kern),
    .wide         (wide)
  );

  addrseg_classify u_cls (
    .vaddr     (req_vaddr),
    .write     (req_write),
    .is_kernel (kern),
    .use_tlb   (comb_rsp.use_tlb),
    .direct    (comb_rsp.direct),
    .addr_err  (comb_rsp.addr_err),
    .paddr     (comb_rsp.paddr),
    .writable  (comb_rsp.writable),
    .code      (comb_rsp.code)
  );

  assign comb_rsp.wide = wide;

  addrseg_outstage #(.REG_OUT(REG_OUT)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (comb_rsp),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (out_rsp)
  );

  assign rsp_use_tlb  = out_rsp.use_tlb;
  assign rsp_direct   = out_rsp.direct;
  assign rsp_paddr    = out_rsp.paddr;
  assign rsp_writable = out_rsp.writable;
  assign rsp_addr_err = out_rsp.addr_err;
  assign rsp_exc_code = out_rsp.code;
  assign rsp_wide     = out_rsp.wide;

  // R9
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_use_tlb, rsp_direct, rsp_addr_err}) == 1));

  // R8
  err_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_addr_err) |->
      ((rsp_exc_code == EXC_ADDR_LOAD || rsp_exc_code == EXC_ADDR_STORE) &&
       !rsp_writable && rsp_paddr == '0));

  // R1
  kernel_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && kern) |-> !comb_rsp.addr_err);

  // R4
  low_seg_tlb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_vaddr[VA_W-1:31] == '0) |-> comb_rsp.use_tlb);

  // R6
  direct_writable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_direct) |-> (rsp_writable && rsp_exc_code == '0));
endmodule

// File: tb/addrseg_decoder_test.sv
module addrseg_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  mode_priv = 2'b00;
  logic        mode_exc_lvl = 1'b0, mode_err_lvl = 1'b0;
  logic        wide_user = 1'b0, wide_super = 1'b0, wide_kern = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_use_tlb, rsp_direct, rsp_writable, rsp_addr_err, rsp_wide;
  logic [43:0] rsp_paddr;
  logic [4:0]  rsp_exc_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  addrseg_decoder uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .mode_priv(mode_priv),
    .mode_exc_lvl(mode_exc_lvl), .mode_err_lvl(mode_err_lvl),
    .wide_user(wide_user), .wide_super(wide_super), .wide_kern(wide_kern),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_use_tlb(rsp_use_tlb),
    .rsp_direct(rsp_direct), .rsp_paddr(rsp_paddr), .rsp_writable(rsp_writable),
    .rsp_addr_err(rsp_addr_err), .rsp_exc_code(rsp_exc_code), .rsp_wide(rsp_wide)
  );

  typedef struct packed {
    logic [63:0] va;
    logic        wr;
    logic [1:0]  pv;
    logic        exl, erl, ux, sx, kx;
    logic [2:0]  outc;
    logic [43:0] pa;
    logic        wrt;
    logic [4:0]  code;
    logic        wide;
    logic [7:0]  req;
  } vec_t;

  localparam logic [2:0] TLB = 3'b100, DIR = 3'b010, ERR = 3'b001;
  localparam int NV = 16;
  localparam vec_t VT [NV] = '{
    '{64'h0000_0000_1234_5678, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, TLB, 44'h0, 1'b0, 5'd0, 1'b0, 8'd4}, // R4 user low
    '{64'h0000_0000_7FFF_FFFF, 1'b1, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, TLB, 44'h0, 1'b0, 5'd0, 1'b1, 8'd4}, // R4 edge, R2 user
    '{64'h8000_0000_0000_1000, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, DIR, 44'h1000, 1'b1, 5'd0, 1'b0, 8'd3}, // R3 user
    '{64'hB123_4567_89AB_CDEF, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, DIR, 44'h567_89AB_CDEF, 1'b1, 5'd0, 1'b1, 8'd3}, // R3 kernel
    '{64'hFFFF_FFFF_8000_1234, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, DIR, 44'h1234, 1'b1, 5'd0, 1'b0, 8'd6}, // R6
    '{64'hFFFF_FFFF_BFFF_FFFF, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, DIR, 44'h1FFF_FFFF, 1'b1, 5'd0, 1'b0, 8'd6}, // R6 top edge
    '{64'hFFFF_FFFF_C000_0000, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, TLB, 44'h0, 1'b0, 5'd0, 1'b1, 8'd7}, // R7 past window
    '{64'h0000_0000_A000_0010, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, DIR, 44'h10, 1'b1, 5'd0, 1'b0, 8'd5}, // R5 extended
    '{64'h0000_0001_8000_0000, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, TLB, 44'h0, 1'b0, 5'd0, 1'b0, 8'd5}, // R5 not extended
    '{64'h0000_0000_A000_0010, 1'b0, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, ERR, 44'h0, 1'b0, 5'd4, 1'b1, 8'd8}, // R8 load
    '{64'hFFFF_FFFF_8000_0000, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, ERR, 44'h0, 1'b0, 5'd5, 1'b1, 8'd8}, // R8 store, R2 super
    '{64'hFFFF_FFFF_8000_0000, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, DIR, 44'h0, 1'b1, 5'd0, 1'b1, 8'd1}, // R1 exc level
    '{64'hC000_0000_0000_0000, 1'b0, 2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, TLB, 44'h0, 1'b0, 5'd0, 1'b0, 8'd1}, // R1 err level
    '{64'h0000_0000_8000_0000, 1'b0, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, ERR, 44'h0, 1'b0, 5'd4, 1'b1, 8'd1}, // R1 code 11 user
    '{64'h4000_0000_0000_0000, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, TLB, 44'h0, 1'b0, 5'd0, 1'b0, 8'd7}, // R7
    '{64'h0000_0000_0000_0040, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, TLB, 44'h0, 1'b0, 5'd0, 1'b1, 8'd2}  // R2 super
  };

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_vaddr = v.va; req_write = v.wr; mode_priv = v.pv;
    mode_exc_lvl = v.exl; mode_err_lvl = v.erl;
    wide_user = v.ux; wide_super = v.sx; wide_kern = v.kx;
    req_valid = 1'b1;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    string rq;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk("R10", "rsp_valid", rsp_valid, 0);
    chk("R10", "fields", {rsp_use_tlb, rsp_direct, rsp_addr_err, rsp_paddr, rsp_exc_code}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VT[i]);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      rq = $sformatf("R%0d", VT[i].req);
      chk("R10", "rsp_valid", rsp_valid, 1);
      chk(rq, "outcome", {rsp_use_tlb, rsp_direct, rsp_addr_err}, VT[i].outc);
      chk("R9", "one-hot", $countones({rsp_use_tlb, rsp_direct, rsp_addr_err}), 1);
      chk(rq, "paddr", rsp_paddr, VT[i].pa);
      chk(rq, "writable", rsp_writable, VT[i].wrt);
      chk(rq, "code", rsp_exc_code, VT[i].code);
      chk("R2", "wide", rsp_wide, VT[i].wide);
    end

    // R10 back-pressure: response held while consumer stalls
    @(negedge clk);
    chk("R10", "idle rsp_valid", rsp_valid, 0);
    rsp_ready = 1'b0;
    drive(VT[5]);
    @(posedge clk);
    @(negedge clk);
    drive(VT[9]);
    for (int k = 0; k < 3; k++) begin
      chk("R10", "stall ready", req_ready, 0);
      chk("R10", "stall paddr", rsp_paddr, 44'h1FFF_FFFF);
      chk("R10", "stall outcome", {rsp_use_tlb, rsp_direct, rsp_addr_err}, DIR);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10", "next rsp_valid", rsp_valid, 1);
    chk("R8", "queued outcome", {rsp_use_tlb, rsp_direct, rsp_addr_err}, ERR);
    chk("R8", "queued code", rsp_exc_code, 5'd4);
    @(negedge clk);
    chk("R10", "drained", rsp_valid, 0);

    // R10 reset mid-run clears the stage
    drive(VT[0]);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10", "reset clears valid", rsp_valid, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule